// File: doc/BRIEF.md
# Slot Network Interrupt Aggregator

This block gathers network interrupt events from up to seven expansion slots into 32-bit status words that software can read. Each slot has several ports. The device side reports an event as a one-cycle set or clear pulse, together with a slot number and a port number. The block converts that slot and port pair into a single status bit and holds the bit until a clear pulse for the same slot and port removes it. A single interrupt line to the processor is high whenever any held bit is set.

The `layout_b` input selects one of two chassis layouts. It is static and may change only while reset is held.

- **Layout A** uses one status word and only four slots. Software reads that word one byte at a time.
- **Layout B** uses all seven slots. It places slot 0 in a second status word and packs the other six slots into the first word. Software reads each word whole.

In both layouts the slot bit ranges sit in an irregular order inside a word. They do not follow slot number.

Reads are combinational, so `rd_data` follows `rd_addr` in the same cycle. A read has no side effect on the status bits.

Top module: `net_irq_agg`

## Requirements
- R1: While reset is low and on its release, every status bit is 0, `irq` is 0 and every read address returns 0.
- R2: In layout A (`layout_b`=0), a set pulse for slot s and port p sets bit (base+p) of word 0 on the next clock edge. The base is 16 for slot 0, 24 for slot 1, 0 for slot 2 and 8 for slot 3.
- R3: A clear pulse for a slot and port clears the same bit that a set pulse for that slot and port would set, on the next clock edge.
- R4: In layout A, events that name slot 4, 5, 6 or 7 change no status bit. In layout B, events that name slot 7 change no status bit.
- R5: In layout B (`layout_b`=1), slot 0 maps to word 1 with base 0. The other slots map to word 0 with these bases: slot 6 base 0, slot 5 base 8, slot 2 base 16, slot 4 base 20, slot 1 base 24, slot 3 base 28.
- R6: An event whose base plus port exceeds 31 changes no status bit.
- R7: `irq` is 1 exactly when some bit is set: any bit of word 0 in layout A, or any bit of either word in layout B. It follows the status bits, so it changes in the cycle after the event that altered them.
- R8: In layout A, the byte read addresses are:
  - 0x20000 returns word 0 bits 31:24;
  - 0x20001 returns bits 23:16;
  - 0x20002 returns bits 15:8;
  - 0x20003 returns bits 7:0.

  Each byte is returned in `rd_data[7:0]`, and the upper bits of `rd_data` are zero.
- R9: In layout B, address 0x10010 returns all of word 0 and address 0x20010 returns all of word 1.
- R10: Reading any address leaves every status bit unchanged.
- R11: If a set and a clear name the same bit in the same cycle, the bit ends up set. If they name different bits, both take effect.
- R12: Any address not listed for the active layout reads as 0. This includes the layout B addresses when layout A is active, and the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| layout_b | input | 1 | Layout select: 0 selects layout A, 1 selects layout B; static outside reset |
| set_vld | input | 1 | Set pulse |
| set_slot | input | SLOT_W (3) | Slot number for the set pulse |
| set_port | input | PORT_W (4) | Port number for the set pulse |
| clr_vld | input | 1 | Clear pulse |
| clr_slot | input | SLOT_W (3) | Slot number for the clear pulse |
| clr_port | input | PORT_W (4) | Port number for the clear pulse |
| rd_addr | input | ADDR_W (20) | Register read offset |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| irq | output | 1 | Combined network interrupt |

## Verification
The bench builds the block with its default widths: a 3-bit slot field, a 4-bit port field and a 20-bit offset.

- **Slot field.** Three bits can name slot 7, which neither layout defines. This lets the bench drive an event for a slot that does not exist.
- **Port field.** Four bits allow port numbers up to 15. With base 28, or with base 24 and port 8 or higher, the bit position passes 31, so the out-of-range rule is reachable.
- **Offset width.** Twenty bits reach every decoded offset in both layouts, so the bench can read each layout's addresses while the other layout is active.

// File: rtl/net_irq_agg.sv
module net_irq_agg #(
  parameter int SLOT_W = 3,
  parameter int PORT_W = 4,
  parameter int ADDR_W = 20,
  parameter logic [ADDR_W-1:0] BYTE_BASE = 20'h20000,
  parameter logic [ADDR_W-1:0] WORD0_ADDR = 20'h10010,
  parameter logic [ADDR_W-1:0] WORD1_ADDR = 20'h20010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              layout_b,
  input  logic              set_vld,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic [PORT_W-1:0] set_port,
  input  logic              clr_vld,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic [PORT_W-1:0] clr_port,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq
);

  localparam int WORDS = 2;
  localparam int STW = 32 * WORDS;

  // Result layout: {valid, word, bit position}
  function automatic logic [6:0] locate(input logic mb,
                                        input logic [SLOT_W-1:0] s,
                                        input logic [PORT_W-1:0] p);
    int base;
    int sum;
    logic wsel;
    logic ok;
    base = 0;
    wsel = 1'b0;
    ok = 1'b1;
    if (!mb) begin
      case (int'(s))
        0: base = 16;
        1: base = 24;
        2: base = 0;
        3: base = 8;
        default: ok = 1'b0;
      endcase
    end else begin
      case (int'(s))
        0: wsel = 1'b1;
        1: base = 24;
        2: base = 16;
        3: base = 28;
        4: base = 20;
        5: base = 8;
        6: base = 0;
        default: ok = 1'b0;
      endcase
    end
    sum = base + int'(p);
    if (sum > 31) ok = 1'b0;
    return {ok, wsel, sum[4:0]};
  endfunction

  logic [6:0]     set_loc, clr_loc;
  logic [STW-1:0] set_m, clr_m;
  logic [STW-1:0] st;

  assign set_loc = locate(layout_b, set_slot, set_port);
  assign clr_loc = locate(layout_b, clr_slot, clr_port);
  assign set_m = (set_vld && set_loc[6]) ? (STW'(1) << set_loc[5:0]) : '0;
  assign clr_m = (clr_vld && clr_loc[6]) ? (STW'(1) << clr_loc[5:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= '0;
    else        st <= (st & ~clr_m) | set_m;
  end

  assign irq = layout_b ? (|st) : (|st[31:0]);

  always_comb begin
    rd_data = '0;
    if (!layout_b) begin
      for (int k = 0; k < 4; k++)
        if (rd_addr == BYTE_BASE + ADDR_W'(k))
          rd_data[7:0] = st[31-8*k -: 8];
    end else begin
      if (rd_addr == WORD0_ADDR) rd_data = st[31:0];
      else if (rd_addr == WORD1_ADDR) rd_data = st[63:32];
    end
  end

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_vld && !clr_vld) |=> $stable(st));

  // R4
  word1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !layout_b |-> st[63:32] == 32'h0);

  // R7
  set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vld && set_loc[6]) |=> irq);

  // R3
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_vld |=> ((($past(st)) & ~st) == '0));

  // R11
  no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_vld |=> $countones(st) <= $countones($past(st)));

endmodule

// File: tb/net_irq_agg_test.sv
`timescale 1ns/1ps
module net_irq_agg_test;
  logic clk = 0;
  logic rst_n = 0;
  logic layout_b = 0;
  logic set_vld = 0, clr_vld = 0;
  logic [2:0] set_slot = 0, clr_slot = 0;
  logic [3:0] set_port = 0, clr_port = 0;
  logic [19:0] rd_addr = 0;
  logic [31:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;
  logic [63:0] mdl = '0;

  always #2.5 clk = ~clk;

  net_irq_agg uut (.clk(clk), .rst_n(rst_n), .layout_b(layout_b),
    .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
    .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  function automatic int bit_index(bit mb, int s, int p);
    int offa[4] = '{16, 24, 0, 8};
    int offb[7] = '{0, 24, 16, 28, 20, 8, 0};
    int pos;
    if (!mb) begin
      if (s > 3) return -1;
      pos = offa[s] + p;
      return (pos > 31) ? -1 : pos;
    end
    if (s > 6) return -1;
    pos = offb[s] + p;
    if (pos > 31) return -1;
    return (s == 0) ? 32 + pos : pos;
  endfunction

  function automatic logic [31:0] model_rd(logic [19:0] a);
    if (!layout_b) begin
      if (a >= 20'h20000 && a <= 20'h20003)
        return {24'h0, 8'(mdl[31:0] >> (8 * (3 - int'(a - 20'h20000))))};
      return 0;
    end
    if (a == 20'h10010) return mdl[31:0];
    if (a == 20'h20010) return mdl[63:32];
    return 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model, compared on every clock
  always @(posedge clk) begin
    int si, ci;
    logic [63:0] sm, cm;
    if (!rst_n) mdl = '0;
    else begin
      sm = '0; cm = '0;
      si = bit_index(layout_b, int'(set_slot), int'(set_port));
      ci = bit_index(layout_b, int'(clr_slot), int'(clr_port));
      if (set_vld && si >= 0) sm[si] = 1'b1;
      if (clr_vld && ci >= 0) cm[ci] = 1'b1;
      mdl = (mdl & ~cm) | sm;
    end
    #2;
    check("R7 irq", {31'h0, irq},
          {31'h0, layout_b ? (|mdl) : (|mdl[31:0])});
    check("R8/R9/R12 read", rd_data, model_rd(rd_addr));
  end

  task automatic ev(bit sv, int ss, int sp, bit cv, int cs, int cp);
    @(negedge clk);
    set_vld = sv; set_slot = 3'(ss); set_port = 4'(sp);
    clr_vld = cv; clr_slot = 3'(cs); clr_port = 4'(cp);
    @(negedge clk);
    set_vld = 0; clr_vld = 0;
  endtask

  task automatic rd(logic [19:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_addr = a;
    #1 check(tag, rd_data, exp);
  endtask

  task automatic irq_is(bit exp, string tag);
    @(negedge clk);
    #1 check(tag, {31'h0, irq}, {31'h0, exp});
  endtask

  task automatic do_reset(bit mb);
    @(negedge clk);
    rst_n = 0; layout_b = mb;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Layout A
    do_reset(0);
    irq_is(0, "R1 irq after reset");
    for (int k = 0; k < 4; k++) rd(20'h20000 + 20'(k), 0, "R1 byte after reset");
    ev(1, 0, 1, 0, 0, 0);
    rd(20'h20001, 32'h02, "R2 slot0 port1");
    irq_is(1, "R7 irq raised");
    ev(1, 1, 0, 0, 0, 0);
    rd(20'h20000, 32'h01, "R2 slot1 port0");
    ev(1, 2, 7, 0, 0, 0);
    rd(20'h20003, 32'h80, "R2 slot2 port7");
    ev(1, 3, 3, 0, 0, 0);
    rd(20'h20002, 32'h08, "R8 slot3 port3");
    rd(20'h20002, 32'h08, "R10 reread unchanged");
    ev(1, 4, 0, 0, 0, 0);
    ev(1, 6, 2, 0, 0, 0);
    ev(1, 7, 1, 0, 0, 0);
    rd(20'h20000, 32'h01, "R4 byte0 after absent slots");
    rd(20'h20001, 32'h02, "R4 byte1 after absent slots");
    rd(20'h20002, 32'h08, "R4 byte2 after absent slots");
    rd(20'h20003, 32'h80, "R4 byte3 after absent slots");
    rd(20'h10010, 0, "R12 layout B word in layout A");
    rd(20'h20004, 0, "R12 unmapped byte");
    ev(1, 1, 8, 0, 0, 0);
    rd(20'h20000, 32'h01, "R6 position 32 ignored");
    ev(1, 1, 7, 0, 0, 0);
    rd(20'h20000, 32'h81, "R6 position 31 accepted");
    ev(1, 2, 0, 1, 2, 0);
    rd(20'h20003, 32'h81, "R11 set wins over clear");
    ev(1, 3, 0, 1, 2, 7);
    rd(20'h20003, 32'h01, "R11 clear of other bit applied");
    rd(20'h20002, 32'h09, "R11 set of other bit applied");
    ev(0, 0, 0, 1, 0, 1);
    rd(20'h20001, 32'h00, "R3 clear slot0 port1");
    ev(0, 0, 0, 1, 1, 0);
    ev(0, 0, 0, 1, 1, 7);
    ev(0, 0, 0, 1, 2, 0);
    ev(0, 0, 0, 1, 3, 0);
    irq_is(1, "R7 irq while one bit left");
    ev(0, 0, 0, 1, 3, 3);
    irq_is(0, "R7 irq after all cleared");
    rd(20'h20002, 32'h00, "R3 byte2 cleared");

    // Layout B
    do_reset(1);
    rd(20'h10010, 0, "R1 word0 after reset");
    rd(20'h20010, 0, "R1 word1 after reset");
    irq_is(0, "R1 irq after reset B");
    ev(1, 0, 3, 0, 0, 0);
    rd(20'h20010, 32'h8, "R5 slot0 in word1");
    irq_is(1, "R7 irq from word1");
    ev(1, 1, 0, 0, 0, 0);
    ev(1, 3, 3, 0, 0, 0);
    ev(1, 3, 4, 0, 0, 0);
    ev(1, 6, 1, 0, 0, 0);
    ev(1, 5, 2, 0, 0, 0);
    ev(1, 4, 0, 0, 0, 0);
    ev(1, 2, 0, 0, 0, 0);
    ev(1, 7, 0, 0, 0, 0);
    rd(20'h10010, 32'h8111_0402, "R5 R6 word0 placement");
    rd(20'h10010, 32'h8111_0402, "R10 reread word0");
    rd(20'h20000, 0, "R12 layout A byte in layout B");
    ev(0, 0, 0, 1, 0, 3);
    rd(20'h20010, 0, "R3 word1 cleared");
    irq_is(1, "R7 irq from word0 only");
    ev(0, 0, 0, 1, 1, 0);
    ev(0, 0, 0, 1, 3, 3);
    ev(0, 0, 0, 1, 6, 1);
    ev(0, 0, 0, 1, 5, 2);
    ev(0, 0, 0, 1, 4, 0);
    ev(0, 0, 0, 1, 2, 0);
    rd(20'h10010, 0, "R3 word0 cleared");
    irq_is(0, "R7 irq low layout B");

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule